// File: doc/BRIEF.md
# Byte-Protocol SMBus Register Target

This block is a target-only SMBus endpoint that gives a host controller access to a byte-wide register file. It watches the open-drain clock and data lines and never drives the clock. A faster system clock samples both lines, cleans them up and turns them into bus events. It can pull the data line low through a single enable output. On the register side it has a plain port: an address, write data with a one-cycle write strobe, and read data that the register file returns in the same cycle as the address.

Four transaction shapes are decoded:
- **Write Byte:** address with write, then a command byte, then a data byte.
- **Read Byte:** address with write, then a command byte, a repeated START, then address with read, after which the target returns one byte.
- **Send Byte:** a single byte after the address.
- **Receive Byte:** one byte returned with no command.

Every command byte that is received in full loads an internal register pointer. Read Byte and Receive Byte both return the register at that pointer. Block, word and checksum protocols are not decoded. Any bytes past the shapes above are left unacknowledged.

The register port has no back-pressure. The register file must take a write in the cycle the strobe is high, and it must present read data in the same cycle as the address. A stream handshake would not fit here, because the bus itself cannot be held off: clock stretching is not used.

Top module: `smbt_reg_target`

## Requirements
- R1: While reset is asserted and immediately after it, the data-line drive enable and the write strobe are both low.
- R2: The target pulls the data line low in the acknowledge bit after an address byte whose upper 7 bits equal the configured address. On any other address it leaves the line released until the next START, and no write strobe follows.
- R3: In Write Byte, the target acknowledges both the command byte and the data byte. It raises the write strobe for exactly one system cycle, with the register address equal to the command byte and the write data equal to the data byte.
- R4: Send Byte loads the register pointer from its single byte. Each later Receive Byte returns the register at that pointer, and the pointer is not changed by the read.
- R5: Read Byte returns the register indexed by its command byte, most significant bit first. Each bit is driven low-active on the data line during the clock-high phase.
- R6: The target changes its data-line drive only while the filtered clock is low. It releases the line for the controller's acknowledge bit after a returned byte, and it stays released until the next START.
- R7: After the data byte of a Write Byte, any further byte receives no acknowledge and causes no write.
- R8: A START or STOP at any bit position abandons the transaction in progress. A partly received command byte does not change the pointer.
- R9: A pulse on either bus line that lasts fewer than FILT_LEN system cycles after synchronization has no effect on the received bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed level of the bus clock line |
| sda_i | input | 1 | Sensed level of the bus data line |
| sda_oe_o | output | 1 | When 1, the data line is pulled low |
| reg_addr_o | output | 8 | Register index (the current pointer) |
| reg_wdata_o | output | 8 | Byte to write |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_rdata_i | input | 8 | Register contents at reg_addr_o, same cycle |

## Verification
The bench builds the target with address 7'h2C and FILT_LEN set to 3, and it runs the bus with 100 system cycles per bit. With FILT_LEN at 3, the bench can inject two-cycle pulses on the clock line and the data line in the middle of a byte. One clock pulse falls in a low phase, and one data pulse falls during a high phase where it would look like a START. The bench then checks that these pulses neither add a bit nor abort the transfer. Because the address is 7'h2C, a wrong address of 7'h2D differs only in its last bit, so a compare that ignores any single address bit is exposed. The slow bit rate leaves room to compare the data-line drive against the reference on every system cycle of every clock-high phase.

// File: rtl/smbt_pkg.sv
package smbt_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_CMD,
    ST_CMD_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_TX
  } smbt_state_e;
endpackage

// File: rtl/smbt_line_filter.sv
module smbt_line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          filt_q;
  logic          s;

  assign s      = sync_q[1];
  assign filt_o = filt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      filt_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      if (s == filt_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_LEN - 1)) begin
        filt_q <= s;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/smbt_bus_events.sv
module smbt_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise  = ~scl_q & scl_f;
  assign scl_fall  = scl_q & ~scl_f;
  assign bus_start = scl_q & scl_f & sda_q & ~sda_f;
  assign bus_stop  = scl_q & scl_f & ~sda_q & sda_f;
endmodule

// File: rtl/smbt_reg_target.sv
module smbt_reg_target
  import smbt_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR = 7'h2C,
  parameter int         FILT_LEN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] reg_addr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  input  logic [BYTE_W-1:0] reg_rdata_i
);
  localparam int NLINES = 2;
  localparam int BCW    = $clog2(BYTE_W + 1);

  logic [NLINES-1:0] raw_w, flt_w;
  logic scl_f, sda_f;
  logic scl_rise, scl_fall, bus_start, bus_stop;

  assign raw_w = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    smbt_line_filter #(.FILT_LEN(FILT_LEN)) u_flt (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (raw_w[g]),
      .filt_o (flt_w[g])
    );
  end

  assign scl_f = flt_w[0];
  assign sda_f = flt_w[1];

  smbt_bus_events u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_f     (scl_f),
    .sda_f     (sda_f),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_start (bus_start),
    .bus_stop  (bus_stop)
  );

  smbt_state_e       state;
  logic [BCW-1:0]    bitcnt;
  logic [BYTE_W-1:0] shreg, ptr_q, tx_q, wdata_q;
  logic              rnw_q, oe_q, we_q;
  logic              rx_state;

  assign rx_state = (state == ST_ADDR) || (state == ST_CMD) || (state == ST_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bitcnt  <= '0;
      shreg   <= '0;
      ptr_q   <= '0;
      tx_q    <= '0;
      wdata_q <= '0;
      rnw_q   <= 1'b0;
      oe_q    <= 1'b0;
      we_q    <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (bus_start) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        oe_q   <= 1'b0;
      end else if (bus_stop) begin
        state  <= ST_IDLE;
        oe_q   <= 1'b0;
      end else begin
        if (rx_state && scl_rise) begin
          shreg  <= {shreg[BYTE_W-2:0], sda_f};
          bitcnt <= bitcnt + 1'b1;
        end
        if (scl_fall) begin
          unique case (state)
            ST_ADDR, ST_CMD, ST_DATA: begin
              if (bitcnt == BCW'(BYTE_W)) begin
                bitcnt <= '0;
                if (state == ST_ADDR) begin
                  if (shreg[BYTE_W-1:1] == SLV_ADDR) begin
                    rnw_q <= shreg[0];
                    oe_q  <= 1'b1;
                    state <= ST_ADDR_ACK;
                  end else begin
                    state <= ST_IDLE;
                  end
                end else if (state == ST_CMD) begin
                  ptr_q <= shreg;
                  oe_q  <= 1'b1;
                  state <= ST_CMD_ACK;
                end else begin
                  wdata_q <= shreg;
                  we_q    <= 1'b1;
                  oe_q    <= 1'b1;
                  state   <= ST_DATA_ACK;
                end
              end
            end
            ST_ADDR_ACK: begin
              bitcnt <= '0;
              if (rnw_q) begin
                tx_q  <= reg_rdata_i;
                oe_q  <= ~reg_rdata_i[BYTE_W-1];
                state <= ST_TX;
              end else begin
                oe_q  <= 1'b0;
                state <= ST_CMD;
              end
            end
            ST_CMD_ACK: begin
              oe_q  <= 1'b0;
              state <= ST_DATA;
            end
            ST_DATA_ACK: begin
              oe_q  <= 1'b0;
              state <= ST_IDLE;
            end
            ST_TX: begin
              if (bitcnt == BCW'(BYTE_W - 1)) begin
                oe_q  <= 1'b0;
                state <= ST_IDLE;
              end else begin
                bitcnt <= bitcnt + 1'b1;
                tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
                oe_q   <= ~tx_q[BYTE_W-2];
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign sda_oe_o    = oe_q;
  assign reg_we_o    = we_q;
  assign reg_wdata_o = wdata_q;
  assign reg_addr_o  = ptr_q;
endmodule

// File: rtl/smbt_target_chk.sv
module smbt_target_chk
  import smbt_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        sda_oe,
  input logic        reg_we,
  input logic        scl_f,
  input logic        start_ev,
  input logic        stop_ev,
  input smbt_state_e st
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> (!sda_oe && !reg_we));

  // R3
  we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R6
  drive_change_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_f));

  // R6
  idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe);

  // R8
  start_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (st == ST_ADDR));

  // R8
  stop_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (st == ST_IDLE));
endmodule

bind smbt_reg_target smbt_target_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sda_oe   (sda_oe_o),
  .reg_we   (reg_we_o),
  .scl_f    (scl_f),
  .start_ev (bus_start),
  .stop_ev  (bus_stop),
  .st       (state)
);

// File: tb/sim_smbt_reg_target.sv
module sim_smbt_reg_target;
  localparam logic [6:0] ADDR = 7'h2C;
  localparam int         FL   = 3;
  localparam int         Q    = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_h = 1'b1, sda_h = 1'b1;
  logic sda_w, sda_oe, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  int n_chk = 0, n_fail = 0, we_cnt = 0;
  bit exp_drv = 1'b0, mon_en = 1'b0;

  always #5 clk = ~clk;

  assign sda_w     = sda_h & ~sda_oe;
  assign reg_rdata = mem[reg_addr];

  smbt_reg_target #(.SLV_ADDR(ADDR), .FILT_LEN(FL)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_w),
    .sda_oe_o(sda_oe), .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata),
    .reg_we_o(reg_we), .reg_rdata_i(reg_rdata)
  );

  function automatic logic [7:0] pat(int i);
    return 8'(i * 7 + 3);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= pat(i);
    end else if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
    end
  end

  task automatic chk(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  // Reference drive compare on every clock of every clock-high phase (R6, R2, R5)
  always @(negedge clk) begin
    if (rst_n && reg_we) we_cnt++;
    if (mon_en && scl_h) begin
      n_chk++;
      if (sda_oe !== exp_drv) begin
        n_fail++;
        $display("FAIL R6 drive at %0t: actual %0b expected %0b", $time, sda_oe, exp_drv);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    exp_drv = 1'b0; sda_h = 1'b1; tick(Q);
    scl_h = 1'b1; tick(Q);
    sda_h = 1'b0; tick(Q);
    scl_h = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    exp_drv = 1'b0; sda_h = 1'b0; tick(Q);
    scl_h = 1'b1; tick(Q);
    sda_h = 1'b1; tick(2 * Q);
  endtask

  task automatic put_bit(bit b, bit gl_scl, bit gl_sda);
    exp_drv = 1'b0; sda_h = b;
    if (gl_scl) begin
      tick(5); scl_h = 1'b1; tick(FL - 1); scl_h = 1'b0; tick(Q - 5 - (FL - 1));
    end else tick(Q);
    scl_h = 1'b1;
    if (gl_sda) begin
      tick(Q - 5); sda_h = 1'b0; tick(FL - 1); sda_h = b; tick(Q + 5 - (FL - 1));
    end else tick(2 * Q);
    scl_h = 1'b0; tick(Q);
  endtask

  task automatic put_byte(logic [7:0] b, bit exp_ack, string req, bit glitchy = 1'b0);
    bit got;
    for (int i = 7; i >= 0; i--) put_bit(b[i], glitchy && i == 4, glitchy && i == 2);
    sda_h = 1'b1; exp_drv = exp_ack; tick(Q);
    scl_h = 1'b1; tick(Q);
    got = ~sda_w; tick(Q);
    scl_h = 1'b0; tick(Q);
    exp_drv = 1'b0;
    chk(got == exp_ack, req, got, exp_ack);
  endtask

  task automatic get_byte(logic [7:0] expb, string req);
    logic [7:0] v;
    for (int i = 7; i >= 0; i--) begin
      sda_h = 1'b1; exp_drv = ~expb[i]; tick(Q);
      scl_h = 1'b1; tick(Q);
      v[i] = sda_w; tick(Q);
      scl_h = 1'b0; tick(Q);
    end
    sda_h = 1'b1; exp_drv = 1'b0; tick(Q);
    scl_h = 1'b1; tick(2 * Q);
    scl_h = 1'b0; tick(Q);
    chk(v == expb, req, v, expb);
  endtask

  task automatic wr_byte(logic [7:0] cmd, logic [7:0] d, bit glitchy = 1'b0);
    bus_start();
    put_byte({ADDR, 1'b0}, 1'b1, "R2 address ack");
    put_byte(cmd, 1'b1, "R3 command ack");
    put_byte(d, 1'b1, "R3 data ack", glitchy);
    bus_stop();
    exp_mem[cmd] = d;
  endtask

  task automatic rd_byte(logic [7:0] cmd, string req);
    bus_start();
    put_byte({ADDR, 1'b0}, 1'b1, "R2 address ack");
    put_byte(cmd, 1'b1, "R5 command ack");
    bus_start();
    put_byte({ADDR, 1'b1}, 1'b1, "R2 read address ack");
    get_byte(exp_mem[cmd], req);
    bus_stop();
  endtask

  task automatic send_b(logic [7:0] p);
    bus_start();
    put_byte({ADDR, 1'b0}, 1'b1, "R2 address ack");
    put_byte(p, 1'b1, "R4 send byte ack");
    bus_stop();
  endtask

  task automatic recv_b(logic [7:0] p, string req);
    bus_start();
    put_byte({ADDR, 1'b1}, 1'b1, "R2 read address ack");
    get_byte(exp_mem[p], req);
    bus_stop();
  endtask

  task automatic run_all();
    int w0;
    for (int i = 0; i < 256; i++) exp_mem[i] = pat(i);
    tick(3);
    chk(!sda_oe && !reg_we, "R1 reset outputs", {sda_oe, reg_we}, 0);
    rst_n = 1'b1;
    tick(2);
    chk(!sda_oe && !reg_we, "R1 after reset", {sda_oe, reg_we}, 0);
    mon_en = 1'b1;
    tick(Q);

    // R3 Write Byte with single strobe
    w0 = we_cnt;
    wr_byte(8'h10, 8'hA5);
    chk(we_cnt == w0 + 1, "R3 strobe width", we_cnt - w0, 1);
    chk(mem[8'h10] == 8'hA5, "R3 register written", mem[8'h10], 8'hA5);

    // R5 Read Byte of written and untouched registers
    rd_byte(8'h10, "R5 read written");
    rd_byte(8'h33, "R5 read default");

    // R4 Send Byte then two Receive Bytes
    send_b(8'h33);
    recv_b(8'h33, "R4 receive at pointer");
    recv_b(8'h33, "R4 pointer kept");

    // R2 address mismatch in last bit
    w0 = we_cnt;
    bus_start();
    put_byte({7'h2D, 1'b0}, 1'b0, "R2 foreign address nack");
    put_byte(8'h44, 1'b0, "R2 no ack after mismatch");
    put_byte(8'h99, 1'b0, "R2 no ack after mismatch");
    bus_stop();
    chk(we_cnt == w0, "R2 no write on mismatch", we_cnt - w0, 0);
    chk(mem[8'h44] == exp_mem[8'h44], "R2 register unchanged", mem[8'h44], exp_mem[8'h44]);

    // R7 extra byte after Write Byte data
    w0 = we_cnt;
    bus_start();
    put_byte({ADDR, 1'b0}, 1'b1, "R2 address ack");
    put_byte(8'h20, 1'b1, "R3 command ack");
    put_byte(8'h5A, 1'b1, "R3 data ack");
    put_byte(8'hFF, 1'b0, "R7 extra byte nack");
    bus_stop();
    exp_mem[8'h20] = 8'h5A;
    chk(we_cnt == w0 + 1, "R7 single write", we_cnt - w0, 1);
    chk(mem[8'h20] == 8'h5A, "R7 register keeps data", mem[8'h20], 8'h5A);

    // R8 STOP inside command byte leaves pointer
    send_b(8'h40);
    bus_start();
    put_byte({ADDR, 1'b0}, 1'b1, "R2 address ack");
    for (int i = 7; i >= 4; i--) put_bit(1'b1, 1'b0, 1'b0);
    bus_stop();
    recv_b(8'h40, "R8 pointer after STOP abort");

    // R8 repeated START inside command byte
    bus_start();
    put_byte({ADDR, 1'b0}, 1'b1, "R2 address ack");
    for (int i = 7; i >= 5; i--) put_bit(1'b0, 1'b0, 1'b0);
    bus_start();
    put_byte({ADDR, 1'b1}, 1'b1, "R2 read address ack");
    get_byte(exp_mem[8'h40], "R8 pointer after START abort");
    bus_stop();

    // R9 short pulses on both lines inside the data byte
    w0 = we_cnt;
    wr_byte(8'h61, 8'hB7, 1'b1);
    chk(we_cnt == w0 + 1, "R9 one write despite pulses", we_cnt - w0, 1);
    chk(mem[8'h61] == 8'hB7, "R9 data intact", mem[8'h61], 8'hB7);
    rd_byte(8'h61, "R9 readback");
    mon_en = 1'b0;
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule